// File: doc/BRIEF.md
# Dual-Channel Serial ADC Frame Reader

This block is the host-side master for a two-channel, 12-bit successive-approximation converter with a serial read-out. A one-cycle start request in idle lowers chip select. The block then drives a serial clock, derived from the system clock by an even divisor, through the converter's conversion window. It captures twelve data bits from each channel, MSB first, then raises chip select and issues a one-cycle done pulse together with both results. A request that arrives while a frame is running is dropped.

Two configuration inputs are sampled when a frame starts. The first picks the capture edge. Falling-edge capture suits slow serial clocks. Rising-edge capture leaves almost a full serial period for the converter's output access time at fast clocks. The second picks between two read-out modes. In two-line mode each channel is read from its own data input in a 31-clock frame. In one-line mode chip select stays low for 43 clocks, and both results arrive back to back on data line A.

Top module: `adc_frame_reader`

## Requirements
- R1: After reset, chip select is high, the serial clock is high, done is low and both results are zero. Whenever chip select is high, the serial clock is high.
- R2: A start request sampled in idle pulls chip select low at that clock edge. The serial clock then stays high for DIV/2 system cycles before its first falling edge, so that first falling edge never coincides with the chip-select fall.
- R3: While chip select is low, the serial clock has a period of DIV system cycles. Each half lasts DIV/2 cycles.
- R4: A frame contains exactly 31 serial-clock falling edges in two-line mode and exactly 43 in one-line mode, counted while chip select is low. One data bit is captured per channel bit: 12 per line in two-line mode and 24 on line A in one-line mode.
- R5: With falling-edge capture (capture-edge input 0), bits are sampled at falling edges 20 through 31. The first bit sampled is the MSB.
- R6: With rising-edge capture (capture-edge input 1), bits are sampled at rising edges 20 through 31, where rising edge k follows falling edge k. The first bit sampled is the MSB.
- R7: In one-line mode (mode input 1), result A comes from capture edges 20 to 31 on data line A, and result B comes from capture edges 32 to 43 on the same line. Data line B has no effect on either result.
- R8: Chip select rises DIV/2 system cycles after the last capture edge. Done is high for exactly that one cycle, and both results are valid in it.
- R9: A start request made while chip select is low or the frame is finishing is ignored. The running frame keeps its length, and exactly one done pulse is issued.
- R10: The capture-edge and mode inputs are sampled only when a frame starts. Changing them mid-frame has no effect on that frame.
- R11: The results hold their values between done pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Frame request, sampled in idle |
| rise_cap_i | input | 1 | 1: capture on rising serial edge, 0: on falling edge |
| single_pin_i | input | 1 | 1: both channels read from data line A in one 43-clock frame |
| sdata_a_i | input | 1 | Serial data from channel A output |
| sdata_b_i | input | 1 | Serial data from channel B output |
| sclk_o | output | 1 | Serial clock, idles high |
| cs_no | output | 1 | Active-low chip select |
| result_a_o | output | DATA_W | Channel A result |
| result_b_o | output | DATA_W | Channel B result |
| done_o | output | 1 | One-cycle pulse when a frame completes |

## Verification
Every combination of capture edge and line mode is run with all-zeros, all-ones, alternating patterns and MSB/LSB singletons. A walking one on A with its complement on B exposes any bit shift, any bit reversal or any swap of the two channels. The converter model delays its data in two ways. A short delay lets the data pass only if each bit is sampled at falling edges 20 to 31. A long delay lets it pass only if each bit is sampled one half period later, at the rising edges. One-line frames run with noise on line B to show that line is ignored. One further frame receives a start pulse and has both configuration inputs toggled mid-frame, which separates a controller that latches its configuration from one that restarts or changes mode.

// File: rtl/afr_pkg.sv
package afr_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_LEAD,
    ST_RUN,
    ST_TAIL
  } afr_state_e;
endpackage

// File: rtl/afr_tick.sv
module afr_tick #(
  parameter int HALF = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  output logic tick_o
);
  localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;

  generate
    if (HALF == 1) begin : g_direct
      assign tick_o = en_i;
    end else begin : g_count
      logic [CW-1:0] cnt_q;
      assign tick_o = en_i && (cnt_q == CW'(HALF - 1));
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     cnt_q <= '0;
        else if (!en_i)  cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
      end
      // gap between ticks is one full half period
      assert_tick_spacing_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate
endmodule

// File: rtl/afr_lane.sv
module afr_lane #(
  parameter int W = 12
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         cap_i,
  input  logic         bit_i,
  output logic [W-1:0] sh_o
);
  logic [W-1:0] sh_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    sh_q <= '0;
    else if (cap_i) sh_q <= {sh_q[W-2:0], bit_i};
  end
  assign sh_o = sh_q;
endmodule

// File: rtl/afr_seq.sv
module afr_seq
  import afr_pkg::*;
#(
  parameter int DATA_W    = 12,
  parameter int LEAD_CLKS = 19
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic rise_i,
  input  logic single_i,
  input  logic tick_i,
  output logic run_o,
  output logic sclk_o,
  output logic cs_no,
  output logic cap_o,
  output logic fin_o,
  output logic done_o,
  output logic single_o
);
  localparam int FIRST    = LEAD_CLKS + 1;
  localparam int LAST_TWO = LEAD_CLKS + DATA_W;
  localparam int LAST_ONE = LEAD_CLKS + 2 * DATA_W;
  localparam int CNT_W    = $clog2(LAST_ONE + 1);

  afr_state_e       state_q;
  logic [CNT_W-1:0] fall_q, fall_nx, last_n;
  logic             sclk_q, cs_q, rise_q, single_q, done_q;
  logic             fall_ev, rise_ev, end_ev;

  always_comb begin
    last_n  = single_q ? CNT_W'(LAST_ONE) : CNT_W'(LAST_TWO);
    fall_nx = fall_q + 1'b1;
    fall_ev = (state_q == ST_RUN) && tick_i && sclk_q;
    rise_ev = (state_q == ST_RUN) && tick_i && !sclk_q;
    cap_o   = (fall_ev && !rise_q && (fall_nx >= CNT_W'(FIRST))) ||
              (rise_ev &&  rise_q && (fall_q  >= CNT_W'(FIRST)));
    end_ev  = (fall_ev && !rise_q && (fall_nx == last_n)) ||
              (rise_ev &&  rise_q && (fall_q  == last_n));
    fin_o   = (state_q == ST_TAIL) && tick_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      fall_q   <= '0;
      sclk_q   <= 1'b1;
      cs_q     <= 1'b1;
      rise_q   <= 1'b0;
      single_q <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= fin_o;
      unique case (state_q)
        ST_IDLE: if (start_i) begin
          state_q  <= ST_LEAD;
          cs_q     <= 1'b0;
          fall_q   <= '0;
          rise_q   <= rise_i;
          single_q <= single_i;
        end
        ST_LEAD: if (tick_i) begin
          state_q <= ST_RUN;
          sclk_q  <= 1'b0;
          fall_q  <= CNT_W'(1);
        end
        ST_RUN: if (tick_i) begin
          sclk_q <= !sclk_q;
          if (sclk_q) fall_q <= fall_nx;
          if (end_ev) state_q <= ST_TAIL;
        end
        ST_TAIL: if (tick_i) begin
          sclk_q  <= 1'b1;
          cs_q    <= 1'b1;
          state_q <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign run_o    = (state_q != ST_IDLE);
  assign sclk_o   = sclk_q;
  assign cs_no    = cs_q;
  assign done_o   = done_q;
  assign single_o = single_q;

  // capture tally per frame, checked at completion
  logic [CNT_W-1:0] cap_cnt_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              cap_cnt_q <= '0;
    else if (state_q == ST_IDLE && start_i)   cap_cnt_q <= '0;
    else if (cap_o)                           cap_cnt_q <= cap_cnt_q + 1'b1;
  end

  assert_idle_clk_high_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_q |-> sclk_q);
  assert_no_coincident_fall_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_q) |-> !$past(cs_q));
  assert_cap_in_frame_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cap_o |-> !cs_q);
  assert_cap_count_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin_o |-> (cap_cnt_q == (single_q ? CNT_W'(2 * DATA_W) : CNT_W'(DATA_W))));
  assert_done_with_cs_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> $rose(cs_q));
endmodule

// File: rtl/adc_frame_reader.sv
module adc_frame_reader #(
  parameter int DIV       = 4,
  parameter int DATA_W    = 12,
  parameter int LEAD_CLKS = 19
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rise_cap_i,
  input  logic              single_pin_i,
  input  logic              sdata_a_i,
  input  logic              sdata_b_i,
  output logic              sclk_o,
  output logic              cs_no,
  output logic [DATA_W-1:0] result_a_o,
  output logic [DATA_W-1:0] result_b_o,
  output logic              done_o
);
  localparam int HALF   = DIV / 2;
  localparam int WIDE_W = 2 * DATA_W;

  logic              run, tick, cap, fin, single;
  logic [WIDE_W-1:0] sh_a;
  logic [DATA_W-1:0] sh_b;
  logic [DATA_W-1:0] res_a_q, res_b_q;

  afr_tick #(.HALF(HALF)) u_tick (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .en_i  (run),
    .tick_o(tick)
  );

  afr_seq #(.DATA_W(DATA_W), .LEAD_CLKS(LEAD_CLKS)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .rise_i  (rise_cap_i),
    .single_i(single_pin_i),
    .tick_i  (tick),
    .run_o   (run),
    .sclk_o  (sclk_o),
    .cs_no   (cs_no),
    .cap_o   (cap),
    .fin_o   (fin),
    .done_o  (done_o),
    .single_o(single)
  );

  // line A holds two results in one-line mode
  afr_lane #(.W(WIDE_W)) u_lane_a (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap),
    .bit_i (sdata_a_i),
    .sh_o  (sh_a)
  );

  afr_lane #(.W(DATA_W)) u_lane_b (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .cap_i (cap),
    .bit_i (sdata_b_i),
    .sh_o  (sh_b)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      res_a_q <= '0;
      res_b_q <= '0;
    end else if (fin) begin
      res_a_q <= single ? sh_a[WIDE_W-1:DATA_W] : sh_a[DATA_W-1:0];
      res_b_q <= single ? sh_a[DATA_W-1:0]      : sh_b;
    end
  end

  assign result_a_o = res_a_q;
  assign result_b_o = res_b_q;

  assert_hold_a_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_a_q));
  assert_hold_b_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_o |-> $stable(res_b_q));
endmodule

// File: tb/tb_adc_frame_reader.sv
module tb_adc_frame_reader;
  localparam int DIV = 4;
  localparam int H   = DIV / 2;
  localparam int DW  = 12;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0, rise_cap = 1'b0, single_pin = 1'b0;
  logic sda = 1'b0, sdb = 1'b0;
  logic sclk, cs_n, done;
  logic [DW-1:0] res_a, res_b;

  always #2.5 clk = ~clk;

  adc_frame_reader #(.DIV(DIV), .DATA_W(DW), .LEAD_CLKS(19)) dut (
    .clk_i(clk), .rst_ni(rst_n), .start_i(start), .rise_cap_i(rise_cap),
    .single_pin_i(single_pin), .sdata_a_i(sda), .sdata_b_i(sdb),
    .sclk_o(sclk), .cs_no(cs_n), .result_a_o(res_a), .result_b_o(res_b), .done_o(done)
  );

  int checks = 0, errors = 0;
  int cyc = 0, fcnt = 0, rcnt = 0, lead = -1, per_err = 0, dones = 0;
  int t_csfall = 0, t_lastfall = 0, t_endedge = 0, t_csrise = 0;
  int last_n = 31, lat = 1;
  bit rise_m = 0, single_m = 0, done_at_rise = 0;
  logic prev_cs = 1'b1, prev_sclk = 1'b1;
  logic [DW-1:0] va = '0, vb = '0;
  logic [5:0] line_a = '0, line_b = '0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // monitor and converter model, away from the active edge
  always @(negedge clk) begin
    logic ia, ib;
    cyc++;
    if (prev_cs && !cs_n) begin
      t_csfall = cyc; fcnt = 0; rcnt = 0; lead = -1; per_err = 0;
    end
    if (!cs_n && prev_sclk && !sclk) begin
      fcnt++;
      if (fcnt == 1) lead = cyc - t_csfall;
      else if (cyc - t_lastfall != DIV) per_err++;
      t_lastfall = cyc;
      if (!rise_m && fcnt == last_n) t_endedge = cyc;
    end
    if (!cs_n && !prev_sclk && sclk) begin
      rcnt++;
      if (cyc - t_lastfall != H) per_err++;
      if (rise_m && rcnt == last_n) t_endedge = cyc;
    end
    if (!prev_cs && cs_n) begin
      t_csrise = cyc; done_at_rise = done;
    end
    if (done) dones++;
    prev_cs = cs_n; prev_sclk = sclk;
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    ia = 1'b0; ib = 1'b0;
    if (!cs_n && fcnt >= 19 && fcnt <= 30) begin
      ia = va[30 - fcnt]; ib = vb[30 - fcnt];
    end else if (!cs_n && fcnt >= 31 && fcnt <= 42) begin
      ia = vb[42 - fcnt]; ib = va[42 - fcnt];
    end
    if (single_m) ib = lfsr[0];
    line_a = {line_a[4:0], ia};
    line_b = {line_b[4:0], ib};
    sda = line_a[lat-1];
    sdb = line_b[lat-1];
  end

  task automatic run_frame(input bit rise, input bit single, input logic [DW-1:0] a,
                           input logic [DW-1:0] b, input bit disturb);
    string rq;
    int waited;
    @(negedge clk);
    rise_cap = rise; single_pin = single; rise_m = rise; single_m = single;
    va = a; vb = b; lat = rise ? 5 : 1; last_n = single ? 43 : 31; dones = 0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    waited = 0;
    while (dones == 0 && waited < 1000) begin
      @(negedge clk);
      waited++;
      if (disturb && waited == 40) begin
        start = 1'b1; rise_cap = !rise; single_pin = !single;  // R9 R10
      end
      if (disturb && waited == 41) start = 1'b0;
    end
    repeat (3 * DIV) @(negedge clk);
    rise_cap = rise; single_pin = single;
    rq = single ? "R7" : (rise ? "R6" : "R5");
    check(res_a == a, rq, "result A", res_a, a);
    check(res_b == b, rq, "result B", res_b, b);
    check(fcnt == last_n, "R4", "falling edges", fcnt, last_n);
    check(lead == H, "R2", "lead gap", lead, H);
    check(per_err == 0, "R3", "period errors", per_err, 0);
    check(t_csrise - t_endedge == H, "R8", "tail gap", t_csrise - t_endedge, H);
    check(done_at_rise, "R8", "done with cs rise", done_at_rise, 1);
    check(dones == 1, disturb ? "R9" : "R8", "done pulses", dones, 1);
    if (disturb) check(cs_n == 1'b1, "R10", "idle after frame", cs_n, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(cs_n == 1'b1, "R1", "cs after reset", cs_n, 1);
    check(sclk == 1'b1, "R1", "sclk after reset", sclk, 1);
    check(done == 1'b0, "R1", "done after reset", done, 0);
    check(res_a == '0 && res_b == '0, "R1", "results after reset", res_a | res_b, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int m = 0; m < 4; m++) begin
      bit r = m[0];
      bit s = m[1];
      run_frame(r, s, 12'h000, 12'hFFF, 0);
      run_frame(r, s, 12'hFFF, 12'h000, 0);
      run_frame(r, s, 12'hA5A, 12'h5A5, 0);
      run_frame(r, s, 12'h800, 12'h001, 0);
      run_frame(r, s, 12'h001, 12'h800, 0);
      for (int i = 0; i < DW; i++) begin
        logic [DW-1:0] w = DW'(1) << i;
        run_frame(r, s, w, ~w, 0);
      end
    end
    run_frame(1'b0, 1'b0, 12'h3C7, 12'hC38, 1);
    run_frame(1'b1, 1'b1, 12'h6E1, 12'h19E, 1);
    // R11: results hold while idle
    repeat (20 * DIV) @(negedge clk);
    check(res_a == 12'h6E1, "R11", "hold A", res_a, 12'h6E1);
    check(res_b == 12'h19E, "R11", "hold B", res_b, 12'h19E);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule